// File: doc/BRIEF.md
# Conversion Result Register Pair with Read Lock

This block stores the 10-bit result of an analog-to-digital conversion and offers it to a processor as two 8-bit read-only registers. The upper eight result bits appear in the high register. The two lowest result bits sit at the top of the low register, and the remaining low-register bits read as zero. A mode input can present the result in signed form, which inverts the most significant result bit as it is read.

Every conversion-complete strobe loads a new result. The exception is while a read sequence is in progress. A read of the high register locks the stored pair. A later read of the low register releases the lock. Any result that completes while the pair is locked is discarded, so the two bytes always belong to the same conversion.

The same block also decodes a 5-bit channel code. The outputs are a one-hot external-input select plus separate strobes for the high reference, the low reference and converter power-down. Codes with no assigned meaning assert none of these outputs.

Top module: `adc_result_regs`

## Requirements
- R1: With signed mode off, reading address 0 returns result bits 9..2, with result bit 9 in data bit 7.
- R2: Reading address 1 returns result bit 1 in data bit 7 and result bit 0 in data bit 6. Data bits 5..0 are always 0.
- R3: When done_i is high, the pair is not locked and no read of address 0 or 1 occurs that cycle, res_i is stored at the clock edge.
- R4: A read of address 0 locks the pair. While it is locked, completed conversions are discarded, and both addresses keep returning the stored result.
- R5: A read of address 1 clears the lock. The next done_i after that read stores its result normally.
- R6: A done_i in the same cycle as a read of address 0 or address 1 is discarded, and the read returns the value held before that cycle.
- R7: With signed_mode_i high, data bit 7 of address 0 is the inverse of result bit 9. All other bits of both registers are unchanged.
- R8: Addresses 2 and 3 read as 0.
- R9: Channel codes 0 to 7 assert only in_sel_o bit n, where n equals the code.
- R10: Code 29 asserts only ref_hi_sel_o, code 30 only ref_lo_sel_o, and code 31 only pwr_dn_o. Codes 8 to 28 assert no select output. At most one select output is ever high.
- R11: Reset clears the lock but leaves the stored result intact. After reset, the next done_i is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (clears lock only) |
| res_i | input | 10 | Conversion result |
| done_i | input | 1 | Conversion-complete strobe |
| signed_mode_i | input | 1 | 1 = invert result MSB when read |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address: 0 high, 1 low |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| ch_sel_i | input | 5 | Channel code |
| in_sel_o | output | 8 | One-hot external input select |
| ref_hi_sel_o | output | 1 | High reference selected |
| ref_lo_sel_o | output | 1 | Low reference selected |
| pwr_dn_o | output | 1 | Converter power-down |

## Verification
The bench builds the block with its default parameters: a 10-bit result, 8-bit registers, a 2-bit address and a 5-bit code with eight external inputs. At these sizes every channel code and every address can be visited exhaustively. The bench therefore sweeps all 32 codes and all four addresses, including the two unmapped ones. With a 10-bit result, the split across bytes leaves exactly two bits in the low register. This makes both the zero padding and the inverted bit 9 of the signed mode visible on every read. The bench also applies random strobes together with reads, which exercises the same-cycle drop rule and the lock window many times.

// File: rtl/adc_result_pkg.sv
package adc_result_pkg;
  localparam int unsigned RES_W_DEF  = 10;
  localparam int unsigned BYTE_W_DEF = 8;
  localparam int unsigned CODE_W_DEF = 5;
  localparam int unsigned N_EXT_DEF  = 8;
  localparam int unsigned ADDR_W_DEF = 2;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_HI   = 2'd1,
    RD_LO   = 2'd2,
    RD_OTH  = 2'd3
  } rd_kind_e;
endpackage

// File: rtl/adc_result_store.sv
module adc_result_store #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RES_W-1:0] res_i,
  input  logic             done_i,
  input  logic             hi_rd_i,
  input  logic             lo_rd_i,
  output logic [RES_W-1:0] res_o,
  output logic             lock_o
);
  logic [RES_W-1:0] res_q;
  logic             lock_q;
  logic             take;

  // any read of the pair in the same cycle blocks the capture
  assign take = done_i && !lock_q && !hi_rd_i && !lo_rd_i;

  // result is deliberately not reset
  always_ff @(posedge clk_i) begin
    if (take) res_q <= res_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lock_q <= 1'b0;
    else if (hi_rd_i) lock_q <= 1'b1;
    else if (lo_rd_i) lock_q <= 1'b0;
  end

  assign res_o  = res_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/adc_result_format.sv
module adc_result_format #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [RES_W-1:0]  res_i,
  input  logic              signed_i,
  input  adc_result_pkg::rd_kind_e kind_i,
  output logic [BYTE_W-1:0] data_o
);
  localparam int unsigned LO_BITS = RES_W - BYTE_W;

  logic [BYTE_W-1:0] hi_byte;
  logic [BYTE_W-1:0] lo_byte;

  always_comb begin
    hi_byte = res_i[RES_W-1 -: BYTE_W];
    hi_byte[BYTE_W-1] = res_i[RES_W-1] ^ signed_i;
  end

  generate
    if (LO_BITS > 0) begin : g_lo
      assign lo_byte = {res_i[LO_BITS-1:0], {(BYTE_W-LO_BITS){1'b0}}};
    end else begin : g_no_lo
      assign lo_byte = '0;
    end
  endgenerate

  always_comb begin
    unique case (kind_i)
      adc_result_pkg::RD_HI: data_o = hi_byte;
      adc_result_pkg::RD_LO: data_o = lo_byte;
      default:               data_o = '0;
    endcase
  end
endmodule

// File: rtl/adc_chan_decode.sv
module adc_chan_decode #(
  parameter int unsigned CODE_W      = 5,
  parameter int unsigned N_EXT       = 8,
  parameter int unsigned REF_HI_CODE = 29,
  parameter int unsigned REF_LO_CODE = 30,
  parameter int unsigned PWR_CODE    = 31
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [N_EXT-1:0]  in_sel_o,
  output logic              ref_hi_o,
  output logic              ref_lo_o,
  output logic              pwr_dn_o
);
  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    assign in_sel_o[g] = (code_i == CODE_W'(g));
  end

  assign ref_hi_o = (code_i == CODE_W'(REF_HI_CODE));
  assign ref_lo_o = (code_i == CODE_W'(REF_LO_CODE));
  assign pwr_dn_o = (code_i == CODE_W'(PWR_CODE));
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
  parameter int unsigned RES_W       = adc_result_pkg::RES_W_DEF,
  parameter int unsigned BYTE_W      = adc_result_pkg::BYTE_W_DEF,
  parameter int unsigned ADDR_W      = adc_result_pkg::ADDR_W_DEF,
  parameter int unsigned CODE_W      = adc_result_pkg::CODE_W_DEF,
  parameter int unsigned N_EXT       = adc_result_pkg::N_EXT_DEF,
  parameter int unsigned HI_ADDR     = 0,
  parameter int unsigned LO_ADDR     = 1,
  parameter int unsigned REF_HI_CODE = 29,
  parameter int unsigned REF_LO_CODE = 30,
  parameter int unsigned PWR_CODE    = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RES_W-1:0]  res_i,
  input  logic              done_i,
  input  logic              signed_mode_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [CODE_W-1:0] ch_sel_i,
  output logic [N_EXT-1:0]  in_sel_o,
  output logic              ref_hi_sel_o,
  output logic              ref_lo_sel_o,
  output logic              pwr_dn_o
);
  import adc_result_pkg::*;

  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(HI_ADDR);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(LO_ADDR);

  rd_kind_e         kind;
  logic             hi_rd, lo_rd;
  logic [RES_W-1:0] res_held;
  logic             lock_q;

  always_comb begin
    if (addr_i == A_HI)      kind = RD_HI;
    else if (addr_i == A_LO) kind = RD_LO;
    else                     kind = RD_OTH;
  end

  assign hi_rd = rd_en_i && (kind == RD_HI);
  assign lo_rd = rd_en_i && (kind == RD_LO);

  adc_result_store #(.RES_W(RES_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .res_i   (res_i),
    .done_i  (done_i),
    .hi_rd_i (hi_rd),
    .lo_rd_i (lo_rd),
    .res_o   (res_held),
    .lock_o  (lock_q)
  );

  adc_result_format #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
    .res_i    (res_held),
    .signed_i (signed_mode_i),
    .kind_i   (kind),
    .data_o   (rdata_o)
  );

  adc_chan_decode #(
    .CODE_W(CODE_W), .N_EXT(N_EXT),
    .REF_HI_CODE(REF_HI_CODE), .REF_LO_CODE(REF_LO_CODE), .PWR_CODE(PWR_CODE)
  ) u_dec (
    .code_i   (ch_sel_i),
    .in_sel_o (in_sel_o),
    .ref_hi_o (ref_hi_sel_o),
    .ref_lo_o (ref_lo_sel_o),
    .pwr_dn_o (pwr_dn_o)
  );
endmodule

// File: rtl/adc_result_regs_chk.sv
module adc_result_regs_chk #(
  parameter int unsigned RES_W    = 10,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned N_EXT    = 8,
  parameter int unsigned HI_ADDR  = 0,
  parameter int unsigned LO_ADDR  = 1,
  parameter int unsigned PWR_CODE = 31
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [RES_W-1:0]  res_i,
  input logic              done_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BYTE_W-1:0] rdata_o,
  input logic [CODE_W-1:0] ch_sel_i,
  input logic [N_EXT-1:0]  in_sel_o,
  input logic              ref_hi_sel_o,
  input logic              ref_lo_sel_o,
  input logic              pwr_dn_o,
  input logic              lock_i,
  input logic [RES_W-1:0]  hold_i
);
  localparam int unsigned LO_BITS = RES_W - BYTE_W;

  logic hi_rd, lo_rd;
  assign hi_rd = rd_en_i && (addr_i == ADDR_W'(HI_ADDR));
  assign lo_rd = rd_en_i && (addr_i == ADDR_W'(LO_ADDR));

  AST_UPDATE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !lock_i && !hi_rd && !lo_rd) |=> (hold_i == $past(res_i))); // R3
  AST_LOCK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_rd |=> lock_i); // R4
  AST_HOLD_WHILE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(hold_i)); // R4
  AST_LOCK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_rd |=> !lock_i); // R5
  AST_READ_DROPS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_rd || lo_rd) |=> $stable(hold_i)); // R6
  AST_LO_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(LO_ADDR)) |-> (rdata_o[BYTE_W-LO_BITS-1:0] == '0)); // R2
  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({in_sel_o, ref_hi_sel_o, ref_lo_sel_o, pwr_dn_o})); // R10
  AST_PWR_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_sel_i == CODE_W'(PWR_CODE)) |-> (pwr_dn_o && in_sel_o == '0)); // R10
endmodule

bind adc_result_regs adc_result_regs_chk #(
  .RES_W(RES_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W), .N_EXT(N_EXT),
  .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR), .PWR_CODE(PWR_CODE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .res_i(res_i), .done_i(done_i),
  .rd_en_i(rd_en_i), .addr_i(addr_i), .rdata_o(rdata_o), .ch_sel_i(ch_sel_i),
  .in_sel_o(in_sel_o), .ref_hi_sel_o(ref_hi_sel_o), .ref_lo_sel_o(ref_lo_sel_o),
  .pwr_dn_o(pwr_dn_o), .lock_i(lock_q), .hold_i(res_held)
);

// File: tb/sim_adc_result_regs.sv
module sim_adc_result_regs;
  localparam int CLK_P = 10;
  localparam int WDOG  = 20000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] res_i = '0;
  logic       done_i = 1'b0;
  logic       signed_mode_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [1:0] addr_i = 2'd2;
  logic [7:0] rdata_o;
  logic [4:0] ch_sel_i = '0;
  logic [7:0] in_sel_o;
  logic       ref_hi_sel_o, ref_lo_sel_o, pwr_dn_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done_run = 0;

  // reference model state
  int m_res   = 0;
  bit m_valid = 0;
  bit m_lock  = 0;

  adc_result_regs u0 (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > WDOG && !done_run) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic int exp_rdata(int a, bit sm);
    int v;
    if (a == 0) begin
      v = (m_res >> 2) & 8'hFF;
      if (sm) v = v ^ 8'h80;
    end else if (a == 1) v = (m_res & 3) << 6;
    else v = 0;
    return v;
  endfunction

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, check before posedge, advance model after it
  task automatic step(string tag, bit d, int r, bit rd, int a, bit sm, int ch);
    int ex_in, ex_flags;
    @(negedge clk_i);
    done_i = d; res_i = 10'(r); rd_en_i = rd; addr_i = 2'(a);
    signed_mode_i = sm; ch_sel_i = 5'(ch);
    #1;
    if (m_valid || a >= 2) cmp(tag, rdata_o, exp_rdata(a, sm));
    ex_in    = (ch < 8) ? (1 << ch) : 0;
    ex_flags = {ch == 29, ch == 30, ch == 31};
    cmp((ch < 8) ? "R9" : "R10",
        {in_sel_o, ref_hi_sel_o, ref_lo_sel_o, pwr_dn_o}, (ex_in << 3) | ex_flags);
    @(posedge clk_i);
    #1;
    if (d && !m_lock && !(rd && a < 2)) begin m_res = r; m_valid = 1; end
    if (rd && a == 0) m_lock = 1;
    else if (rd && a == 1) m_lock = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    done_i = 0; rd_en_i = 0;
    rst_ni = 0;
    @(negedge clk_i);
    rst_ni = 1;
    m_lock = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    // R8 unmapped addresses read zero, also before any conversion
    step("R8", 0, 0, 1, 2, 0, 0);
    step("R8", 0, 0, 1, 3, 1, 1);
    // R3 capture
    step("R3", 1, 10'h2A5, 0, 2, 0, 2);
    step("R1", 0, 0, 0, 0, 0, 3);
    step("R2", 0, 0, 0, 1, 0, 4);
    // R4 lock via high read, then discarded conversions
    step("R4", 0, 0, 1, 0, 0, 5);
    step("R4", 1, 10'h155, 0, 0, 0, 6);
    step("R4", 1, 10'h3FF, 1, 0, 0, 7);
    step("R4", 0, 0, 0, 1, 0, 8);
    // R5 low read releases, next done stored
    step("R5", 0, 0, 1, 1, 0, 9);
    step("R5", 1, 10'h0C3, 0, 2, 0, 28);
    step("R5", 0, 0, 0, 0, 0, 29);
    step("R5", 0, 0, 0, 1, 0, 30);
    // R6 done together with reads
    step("R6", 1, 10'h1E7, 1, 1, 0, 31);
    step("R6", 0, 0, 0, 0, 0, 0);
    step("R6", 1, 10'h1E7, 1, 0, 0, 1);
    step("R6", 0, 0, 0, 1, 0, 2);
    step("R6", 0, 0, 1, 1, 0, 3);
    // R7 signed presentation
    step("R3", 1, 10'h3A6, 0, 2, 0, 4);
    step("R7", 0, 0, 0, 0, 1, 5);
    step("R7", 0, 0, 0, 1, 1, 6);
    step("R3", 1, 10'h04B, 0, 2, 0, 7);
    step("R7", 0, 0, 0, 0, 1, 8);
    // R9 R10 full code sweep
    for (int c = 0; c < 32; c++) step("R8", 0, 0, 0, 3, 0, c);
    // R11 reset while locked keeps result, clears lock
    step("R11", 0, 0, 1, 0, 0, 0);
    do_reset();
    step("R11", 0, 0, 0, 0, 0, 1);
    step("R11", 1, 10'h2D2, 0, 2, 0, 2);
    step("R11", 0, 0, 0, 0, 0, 3);
    step("R11", 0, 0, 0, 1, 0, 4);
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      int rv;
      rv = $urandom;
      step("R4", rv[0], rv[10:1], rv[11] & rv[12], rv[14:13], rv[15], rv[20:16]);
    end
    done_run = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule